// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It takes the memory from power-up to an idle, programmed state. Once reset is released and the clock-stable input is high, it sends NOP commands through a long settling window. It then closes every bank with one precharge-all and issues two auto-refresh commands. Last, it programs the mode register from a configurable mode word. Each step is separated by a wait counted in clock cycles. All waits are derived from a clock-period parameter and nanosecond timing parameters.

The command pins (chip select, row strobe, column strobe, write enable), the bank address and the row address are all driven from registers. A done flag rises after the mode-register delay and stays high until reset or loss of clock stability. If the clock-stable input drops at any point, the sequencer returns to its holding state, drives command inhibit, and restarts the whole bring-up from the beginning.

Top module: `sdr_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cs_n` is 1 and `init_done` is 0. When `clk_stable` is sampled low on a clock edge, the cycle after it has `sd_cs_n` = 1 and `init_done` = 0.
- R2: After `clk_stable` goes high, the block issues exactly PWRUP_CYC consecutive NOP cycles before its first other command. PWRUP_CYC is ceil(PWRUP_NS*1000/CLK_PERIOD_PS), which is 20000 by default. A NOP is {cs_n,ras_n,cas_n,we_n} = 0111.
- R3: The first command after the NOP window is PRECHARGE (0010). During that cycle address bit 10 is 1, every other address bit is 0, and the bank address is 0.
- R4: The first AUTO REFRESH (0001) follows the precharge after exactly TRP_CYC-1 NOP cycles. TRP_CYC is ceil(TRP_NS*1000/CLK_PERIOD_PS), with a minimum of 2; the default is 4. No refresh appears before a precharge.
- R5: Exactly two AUTO REFRESH commands are issued. Each is followed by exactly TRFC_CYC-1 NOP cycles before the next command. TRFC_CYC is ceil(TRFC_NS*1000/CLK_PERIOD_PS), with a minimum of 2; the default is 14.
- R6: The command after the second refresh is LOAD MODE (0000) with bank address 0. Address bits 9..0 equal `mode_word` bits 9..0, and address bits 12..10 are 0 whatever `mode_word` holds.
- R7: `init_done` rises after exactly TMRD_CYC NOP cycles following LOAD MODE. The default TMRD_CYC is 2. It then stays 1 while `clk_stable` stays high.
- R8: Every command other than NOP or inhibit lasts one cycle and is followed by a NOP. While `init_done` is 1, only NOP is driven.
- R9: Dropping `clk_stable` at any step restarts the sequence from the beginning. This includes the cycle of a command and the cycle `init_done` rises. The restart gives a full PWRUP_CYC NOP window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stable | input | 1 | High once the memory clock is stable; low forces the hold state |
| mode_word | input | ROW_W | Mode value to program; bits 10 and up are ignored |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row address / mode value |
| init_done | output | 1 | High once bring-up is complete |

## Verification
A drop of `clk_stable` can land in the same cycle as a command issue or as the rise of `init_done`, so the restart and a forward step compete. The bench provokes this directly. It removes `clk_stable` in the very cycle the LOAD MODE command is observed, in the cycle `init_done` first shows high, and at a random point inside the NOP window. Each time it requires inhibit and a low done flag on the next cycle, and then a complete, correctly timed sequence with a full-length NOP window.

// File: rtl/sdr_bringup_pkg.sv
package sdr_bringup_pkg;

    // Sequencer steps; each state maps to exactly one command on the bus
    typedef enum logic [3:0] {
        ST_HOLD,
        ST_PWAIT,
        ST_PRE,
        ST_TRP,
        ST_REF1,
        ST_RFC1,
        ST_REF2,
        ST_RFC2,
        ST_MRS,
        ST_TMRD,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_REFRESH,
        CMD_LOAD_MODE
    } cmd_kind_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    // Address bit that selects all banks on precharge
    localparam int unsigned ALL_BANK_BIT = 10;
    // Mode bits that are passed through; higher bits are forced low
    localparam int unsigned MODE_BITS    = 10;

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned floor_at(input int unsigned v,
                                             input int unsigned lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_cmd_encode.sv
module sdr_cmd_encode
    import sdr_bringup_pkg::*;
#(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2
) (
    input  cmd_kind_e         kind,
    input  logic [ROW_W-1:0]  mode_word,
    output cmd_pins_t         pins,
    output logic [ROW_W-1:0]  addr,
    output logic [BANK_W-1:0] ba
);

    always_comb begin
        unique case (kind)
            CMD_NOP:       pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRECHARGE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REFRESH:   pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LOAD_MODE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:       pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

    // Per-bit address selection: mode bits pass through below MODE_BITS,
    // the all-bank bit is raised on precharge, everything else is low.
    for (genvar i = 0; i < ROW_W; i++) begin : g_addr
        if (i < MODE_BITS && i == ALL_BANK_BIT) begin : g_both
            assign addr[i] = (kind == CMD_LOAD_MODE) ? mode_word[i]
                           : (kind == CMD_PRECHARGE);
        end else if (i < MODE_BITS) begin : g_mode
            assign addr[i] = (kind == CMD_LOAD_MODE) & mode_word[i];
        end else if (i == ALL_BANK_BIT) begin : g_ap
            assign addr[i] = (kind == CMD_PRECHARGE);
        end else begin : g_low
            assign addr[i] = 1'b0;
        end
    end

    assign ba = '0;

endmodule

// File: rtl/sdr_bringup_seq.sv
module sdr_bringup_seq
    import sdr_bringup_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned PWRUP_NS      = 100000,
    parameter int unsigned TRP_NS        = 20,
    parameter int unsigned TRFC_NS       = 66,
    parameter int unsigned TMRD_CYC      = 2,
    parameter int unsigned ROW_W         = 13,
    parameter int unsigned BANK_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stable,
    input  logic [ROW_W-1:0]  mode_word,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              init_done
);

    localparam int unsigned PWRUP_CYC = floor_at(ns_to_cycles(PWRUP_NS, CLK_PERIOD_PS), 1);
    localparam int unsigned TRP_CYC   = floor_at(ns_to_cycles(TRP_NS, CLK_PERIOD_PS), 2);
    localparam int unsigned TRFC_CYC  = floor_at(ns_to_cycles(TRFC_NS, CLK_PERIOD_PS), 2);
    localparam int unsigned TMRD_C    = floor_at(TMRD_CYC, 1);
    localparam int unsigned MAX_A     = (PWRUP_CYC > TRFC_CYC) ? PWRUP_CYC : TRFC_CYC;
    localparam int unsigned MAX_WAIT  = (MAX_A > TRP_CYC) ? ((MAX_A > TMRD_C) ? MAX_A : TMRD_C)
                                                          : ((TRP_CYC > TMRD_C) ? TRP_CYC : TMRD_C);
    localparam int unsigned CNT_W     = $clog2(MAX_WAIT + 1);

    localparam logic [CNT_W-1:0] LD_PWRUP = CNT_W'(PWRUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TRP   = CNT_W'(TRP_CYC - 2);
    localparam logic [CNT_W-1:0] LD_TRFC  = CNT_W'(TRFC_CYC - 2);
    localparam logic [CNT_W-1:0] LD_TMRD  = CNT_W'(TMRD_C - 1);

    typedef struct packed {
        seq_state_e        state;
        cmd_pins_t         pins;
        logic [ROW_W-1:0]  addr;
        logic [BANK_W-1:0] ba;
        logic              done;
    } seq_regs_t;

    seq_regs_t seq_d;
    seq_regs_t seq_q;

    logic             tmr_clr;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    cmd_kind_e        kind_d;
    cmd_pins_t        pins_d;
    logic [ROW_W-1:0] addr_d;
    logic [BANK_W-1:0] ba_d;

    sdr_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdr_cmd_encode #(
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_encode (
        .kind      (kind_d),
        .mode_word (mode_word),
        .pins      (pins_d),
        .addr      (addr_d),
        .ba        (ba_d)
    );

    function automatic cmd_kind_e kind_of(input seq_state_e st);
        unique case (st)
            ST_HOLD:         return CMD_INHIBIT;
            ST_PRE:          return CMD_PRECHARGE;
            ST_REF1, ST_REF2: return CMD_REFRESH;
            ST_MRS:          return CMD_LOAD_MODE;
            default:         return CMD_NOP;
        endcase
    endfunction

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_clr  = 1'b0;

        unique case (seq_q.state)
            ST_HOLD: begin
                seq_d.state = ST_PWAIT;
                tmr_load    = 1'b1;
                tmr_val     = LD_PWRUP;
            end
            ST_PWAIT: begin
                if (tmr_expired) seq_d.state = ST_PRE;
            end
            ST_PRE: begin
                seq_d.state = ST_TRP;
                tmr_load    = 1'b1;
                tmr_val     = LD_TRP;
            end
            ST_TRP: begin
                if (tmr_expired) seq_d.state = ST_REF1;
            end
            ST_REF1: begin
                seq_d.state = ST_RFC1;
                tmr_load    = 1'b1;
                tmr_val     = LD_TRFC;
            end
            ST_RFC1: begin
                if (tmr_expired) seq_d.state = ST_REF2;
            end
            ST_REF2: begin
                seq_d.state = ST_RFC2;
                tmr_load    = 1'b1;
                tmr_val     = LD_TRFC;
            end
            ST_RFC2: begin
                if (tmr_expired) seq_d.state = ST_MRS;
            end
            ST_MRS: begin
                seq_d.state = ST_TMRD;
                tmr_load    = 1'b1;
                tmr_val     = LD_TMRD;
            end
            ST_TMRD: begin
                if (tmr_expired) seq_d.state = ST_DONE;
            end
            ST_DONE: begin
                seq_d.state = ST_DONE;
            end
            default: begin
                seq_d.state = ST_HOLD;
            end
        endcase

        // Loss of clock stability overrides any forward step
        if (!clk_stable) begin
            seq_d.state = ST_HOLD;
            tmr_load    = 1'b0;
            tmr_clr     = 1'b1;
        end

        kind_d     = kind_of(seq_d.state);
        seq_d.pins = pins_d;
        seq_d.addr = addr_d;
        seq_d.ba   = ba_d;
        seq_d.done = (seq_d.state == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_HOLD;
            seq_q.pins  <= '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            seq_q.addr  <= '0;
            seq_q.ba    <= '0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sd_cs_n   = seq_q.pins.cs_n;
    assign sd_ras_n  = seq_q.pins.ras_n;
    assign sd_cas_n  = seq_q.pins.cas_n;
    assign sd_we_n   = seq_q.pins.we_n;
    assign sd_addr   = seq_q.addr;
    assign sd_ba     = seq_q.ba;
    assign init_done = seq_q.done;

endmodule

// File: rtl/sdr_bringup_chk.sv
module sdr_bringup_chk #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_stable,
    input logic [ROW_W-1:0]  mode_word,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ROW_W-1:0]  sd_addr,
    input logic              init_done
);

    logic [3:0] bus;
    logic       is_nop;
    logic       is_pre;
    logic       is_ref;
    logic       is_mrs;
    logic       is_cmd;
    logic       pre_seen_q;
    logic [1:0] ref_cnt_q;

    assign bus    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop = (bus == 4'b0111);
    assign is_pre = (bus == 4'b0010);
    assign is_ref = (bus == 4'b0001);
    assign is_mrs = (bus == 4'b0000);
    assign is_cmd = is_pre | is_ref | is_mrs;

    // Observed history since the last inhibit cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_seen_q <= 1'b0;
            ref_cnt_q  <= '0;
        end else if (sd_cs_n) begin
            pre_seen_q <= 1'b0;
            ref_cnt_q  <= '0;
        end else begin
            if (is_pre) pre_seen_q <= 1'b1;
            if (is_ref && ref_cnt_q != 2'd3) ref_cnt_q <= ref_cnt_q + 2'd1;
        end
    end

    p_inhibit_unstable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_stable |=> (sd_cs_n && !init_done));

    p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (sd_addr[10] && sd_ba == '0));

    p_refresh_after_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> pre_seen_q);

    p_two_refreshes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (ref_cnt_q == 2'd2));

    p_mode_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> ((sd_addr >> 10) == '0 && sd_addr[9:0] == $past(mode_word[9:0])
                    && sd_ba == '0));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && clk_stable) |=> init_done);

    p_single_cycle_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> !is_cmd);

    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

endmodule

bind sdr_bringup_seq sdr_bringup_chk #(
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_stable (clk_stable),
    .mode_word  (mode_word),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_ba      (sd_ba),
    .sd_addr    (sd_addr),
    .init_done  (init_done)
);

// File: tb/sdr_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module sdr_bringup_seq_tb_top;

    localparam int unsigned ROW_W  = 13;
    localparam int unsigned BANK_W = 2;

    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned lo);
        int unsigned c;
        c = (ns * 1000 + 4999) / 5000;
        return (c < lo) ? lo : c;
    endfunction

    localparam int unsigned E_PWRUP = cyc_of(100000, 1);
    localparam int unsigned E_TRP   = cyc_of(20, 2);
    localparam int unsigned E_TRFC  = cyc_of(66, 2);
    localparam int unsigned E_TMRD  = 2;

    localparam int K_INH = 0, K_NOP = 1, K_PRE = 2, K_REF = 3, K_MRS = 4,
                   K_BAD = 5, K_DONE = 6, K_TIMEOUT = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_stable = 1'b0;
    logic [ROW_W-1:0]  mode_word = '0;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BANK_W-1:0] sd_ba;
    logic [ROW_W-1:0]  sd_addr;
    logic              init_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    sdr_bringup_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_stable (clk_stable),
        .mode_word  (mode_word),
        .sd_cs_n    (sd_cs_n),
        .sd_ras_n   (sd_ras_n),
        .sd_cas_n   (sd_cas_n),
        .sd_we_n    (sd_we_n),
        .sd_ba      (sd_ba),
        .sd_addr    (sd_addr),
        .init_done  (init_done)
    );

    function automatic int classify();
        case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
            4'b0111: return K_NOP;
            4'b0010: return K_PRE;
            4'b0001: return K_REF;
            4'b0000: return K_MRS;
            default: return sd_cs_n ? K_INH : K_BAD;
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] exp_mode_addr(input logic [ROW_W-1:0] mw);
        return mw & ROW_W'(13'h03FF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Walk forward to the next non-NOP event, counting NOP cycles before it
    task automatic next_event(output int k, output int nops);
        bit stop;
        nops = 0;
        stop = 1'b0;
        k = K_TIMEOUT;
        while (!stop) begin
            @(negedge clk);
            k = classify();
            if (k == K_NOP && !init_done) begin
                nops++;
                if (nops > 40000) begin
                    k = K_TIMEOUT;
                    stop = 1'b1;
                end
            end else begin
                if (k == K_NOP) k = K_DONE;
                stop = 1'b1;
            end
        end
    endtask

    task automatic drop_and_check(input string req);
        clk_stable = 1'b0;
        @(negedge clk);
        check(sd_cs_n == 1'b1, req, sd_cs_n, 1);
        check(init_done == 1'b0, req, init_done, 0);
    endtask

    // Full bring-up with per-step timing checks; stops with done high
    task automatic run_full(input logic [ROW_W-1:0] mw, input string tag);
        int k, n;
        mode_word  = mw;
        clk_stable = 1'b1;
        next_event(k, n);
        check(k == K_PRE, {"R3 first command ", tag}, k, K_PRE);
        check(n == int'(E_PWRUP), {"R2 NOP window ", tag}, n, E_PWRUP);
        check(sd_addr == ROW_W'(13'h0400) && sd_ba == '0, "R3 all-bank address", sd_addr, 13'h0400);
        next_event(k, n);
        check(k == K_REF && n == int'(E_TRP) - 1, "R4 refresh after precharge", n, E_TRP - 1);
        next_event(k, n);
        check(k == K_REF && n == int'(E_TRFC) - 1, "R5 second refresh spacing", n, E_TRFC - 1);
        next_event(k, n);
        check(k == K_MRS && n == int'(E_TRFC) - 1, "R5 mode load spacing", n, E_TRFC - 1);
        check(sd_addr == exp_mode_addr(mw) && sd_ba == '0, "R6 mode value", sd_addr, exp_mode_addr(mw));
        next_event(k, n);
        check(k == K_DONE && n == int'(E_TMRD), "R7 done after tMRD", n, E_TMRD);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(init_done == 1'b1 && classify() == K_NOP, "R7 R8 done held with NOP",
                  classify(), K_NOP);
        end
    endtask

    initial begin
        int k, n, waitn;
        void'($urandom(32'h1d2e3f));

        // Reset state
        clk_stable = 1'b1;
        repeat (4) @(negedge clk);
        check(sd_cs_n == 1'b1 && init_done == 1'b0, "R1 reset inhibit", sd_cs_n, 1);
        check(sd_addr == '0, "R1 reset address", sd_addr, 0);
        clk_stable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sd_cs_n == 1'b1 && init_done == 1'b0, "R1 unstable clock hold", sd_cs_n, 1);

        // Directed: every mode bit set, upper bits must be dropped
        run_full(ROW_W'(13'h1FFF), "all-ones");
        drop_and_check("R1 drop after done");

        // Random drop inside the NOP window, then a complete restart
        clk_stable = 1'b1;
        waitn = 50 + int'($urandom % 5000);
        for (int i = 0; i < waitn; i++) begin
            @(negedge clk);
            if (i > 0) check(classify() == K_NOP, "R2 NOP during wait", classify(), K_NOP);
        end
        drop_and_check("R9 drop in wait");
        run_full(ROW_W'($urandom), "R9 restart after wait drop");

        // Drop in the same cycle the mode load appears
        clk_stable = 1'b0;
        @(negedge clk);
        mode_word  = ROW_W'($urandom);
        clk_stable = 1'b1;
        for (int s = 0; s < 4; s++) next_event(k, n);
        check(k == K_MRS, "R6 mode load reached", k, K_MRS);
        drop_and_check("R9 drop at mode load");
        run_full(ROW_W'($urandom), "R9 restart after mode-load drop");

        // Drop in the cycle done first shows high
        clk_stable = 1'b0;
        @(negedge clk);
        clk_stable = 1'b1;
        for (int s = 0; s < 5; s++) next_event(k, n);
        check(k == K_DONE, "R7 done reached", k, K_DONE);
        drop_and_check("R9 drop at done rise");
        run_full(ROW_W'($urandom), "R9 restart after done drop");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule